// File: doc/BRIEF.md
# Exception Entry Sequencer

This block performs the state changes a 32-bit RISC core with banked privileged modes makes when it takes an exception. A single request line per exception kind (reset, undefined instruction, supervisor call, prefetch abort, data abort, IRQ, FIQ) is sampled together with the live program counter, the status word, the separately held condition flags, the conditional-block (IT) state, the high-vector select and, for aborts, the abort status, address and store flag.

One clock after an accepted request, the block presents the following on registered outputs:

- the new status word;
- the link value, with its write strobe;
- the saved status word, with a one-hot strobe selecting the banked saved-status register of the target mode;
- the packed fault status and fault address, with a strobe per abort kind;
- the new program counter;
- a pulse that sets the event mailbox;
- on reset only, a pulse that clears all pending interrupts.

Choosing between simultaneous requests is the job of the logic in front of this block. A request vector with more than one bit set is dropped.

Top module: `exc_entry`

## Requirements
- R1: Target mode goes into status_next[4:0]: reset and supervisor call give 0x13, undefined gives 0x1B, both aborts give 0x17, IRQ gives 0x12 and FIQ gives 0x11. Exactly one bit of spsr_wr is set, naming the bank of that mode: bit0 FIQ, bit1 IRQ, bit2 supervisor, bit3 undefined, bit4 abort.
- R2: pc_next carries the vector offset: reset 0x00, undefined 0x04, supervisor call 0x08, prefetch abort 0x0C, data abort 0x10, IRQ 0x18, FIQ 0x1C. When vec_high is 1, 0xFFFF0000 is added to it.
- R3: lr_data = pc_cur plus an offset. The offset is picked by status_cur[5], the compact-instruction-set flag. For that flag at 0 / 1 the offsets are:
  - reset 0/0
  - undefined 4/2
  - supervisor call 4/2
  - prefetch abort 4/4
  - data abort 8/8
  - IRQ 4/4
  - FIQ 4/4
- R4: In status_next, bit7 (IRQ mask) is set on every entry. Bit8 (asynchronous-abort mask) is OR-set on reset, both aborts, IRQ and FIQ. Bit6 (FIQ mask) is OR-set only on reset and FIQ. A mask bit that is not set keeps its value from status_cur.
- R5: spsr_data is status_cur with the following fields replaced:
  - [31]=N from flag_nz[1], [30]=Z from flag_nz[0], [29]=C, [28]=V;
  - [19:16] from flag_ge;
  - [15:10] from it_state[7:2];
  - [26:25] from it_state[1:0].

  status_next has both IT fields ([15:10] and [26:25]) cleared.
- R6: On an abort, fsr_wr bit0 (prefetch) or bit1 (data) is set. fsr_data[3:0] = abt_status[3:0], fsr_data[10] = abt_status[4], fsr_data[11] = abt_write, and all other bits are 0. far_data = abt_addr. fsr_wr stays 0 for any other exception.
- R7: mailbox_set pulses with every entry. irq_clear_all pulses only on reset entry.
- R8: All outputs are registered and appear exactly one cycle after the request. entry_valid, lr_wr, spsr_wr, fsr_wr, mailbox_set and irq_clear_all are 0 in any cycle that follows no accepted request, and back-to-back requests are each taken.
- R9: A request vector with more than one bit set is not accepted: no strobe and no entry_valid follow it.
- R10: After reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| exc_req | input | 7 | One-hot request: bit0 reset, 1 undefined, 2 supervisor call, 3 prefetch abort, 4 data abort, 5 IRQ, 6 FIQ |
| pc_cur | input | 32 | Program counter of the excepting point |
| status_cur | input | 32 | Current status word |
| flag_nz | input | 2 | Live N (bit1) and Z (bit0) flags |
| flag_c | input | 1 | Live carry flag |
| flag_v | input | 1 | Live overflow flag |
| flag_ge | input | 4 | Live greater-or-equal flags |
| it_state | input | 8 | Conditional-block state |
| vec_high | input | 1 | Select the high vector base |
| abt_status | input | 5 | Abort cause code |
| abt_addr | input | 32 | Faulting address |
| abt_write | input | 1 | Faulting access was a store |
| entry_valid | output | 1 | Outputs below hold a new entry |
| status_next | output | 32 | New status word |
| spsr_wr | output | 5 | One-hot banked saved-status write strobe |
| spsr_data | output | 32 | Saved status word |
| lr_wr | output | 1 | Link register write strobe |
| lr_data | output | 32 | Link value |
| pc_next | output | 32 | New program counter |
| fsr_wr | output | 2 | Fault register write strobe (bit0 prefetch, bit1 data) |
| fsr_data | output | 32 | Packed fault status |
| far_data | output | 32 | Fault address |
| mailbox_set | output | 1 | Set the event mailbox |
| irq_clear_all | output | 1 | Clear all pending interrupts |

## Verification
The bench goes after the link offset, which depends on both exception kind and instruction-set state. It runs every kind in both states, so a design that used a single offset per kind, or swapped the data-abort and prefetch-abort rows, would produce a wrong lr_data.

Mask bits are checked from both an all-clear and an all-set starting status. This catches a design that clears a mask bit it should keep, or that sets the FIQ mask on an IRQ.

Aborts are driven with cause codes whose bit 4 differs and with both store flag values, which exposes a misplaced high status bit or write flag. Multi-hot, idle and back-to-back cycles expose strobes that leak or entries that are lost.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

   localparam int NUM_EXC = 7;

   typedef enum logic [2:0] {
      EX_RESET = 3'd0,
      EX_UNDEF = 3'd1,
      EX_SVC   = 3'd2,
      EX_PABT  = 3'd3,
      EX_DABT  = 3'd4,
      EX_IRQ   = 3'd5,
      EX_FIQ   = 3'd6
   } exc_kind_e;

   localparam logic [4:0] MODE_FIQ_C = 5'h11;
   localparam logic [4:0] MODE_IRQ_C = 5'h12;
   localparam logic [4:0] MODE_SVC_C = 5'h13;
   localparam logic [4:0] MODE_ABT_C = 5'h17;
   localparam logic [4:0] MODE_UND_C = 5'h1B;

   // saved-status bank strobe positions
   localparam int BANK_FIQ = 0;
   localparam int BANK_IRQ = 1;
   localparam int BANK_SVC = 2;
   localparam int BANK_UND = 3;
   localparam int BANK_ABT = 4;
   localparam int NUM_BANK = 5;

   // status word field positions
   localparam int ST_N      = 31;
   localparam int ST_Z      = 30;
   localparam int ST_C      = 29;
   localparam int ST_V      = 28;
   localparam int ST_ITL_HI = 26;
   localparam int ST_ITL_LO = 25;
   localparam int ST_GE_HI  = 19;
   localparam int ST_GE_LO  = 16;
   localparam int ST_ITH_HI = 15;
   localparam int ST_ITH_LO = 10;
   localparam int ST_A      = 8;
   localparam int ST_I      = 7;
   localparam int ST_F      = 6;
   localparam int ST_T      = 5;

   typedef struct packed {
      logic [4:0]          vec_off;
      logic [4:0]          mode;
      logic [3:0]          lr_wide;
      logic [3:0]          lr_narrow;
      logic                set_a;
      logic                set_f;
      logic [NUM_BANK-1:0] bank;
      logic [1:0]          fault;
      logic                is_reset;
   } exc_attr_t;

   localparam int ATTR_W = $bits(exc_attr_t);

   function automatic exc_attr_t attr_of(input int unsigned k);
      exc_attr_t a;
      a = '0;
      case (k)
         0: begin
            a.vec_off = 5'h00; a.mode = MODE_SVC_C;
            a.set_a = 1'b1; a.set_f = 1'b1;
            a.bank[BANK_SVC] = 1'b1; a.is_reset = 1'b1;
         end
         1: begin
            a.vec_off = 5'h04; a.mode = MODE_UND_C;
            a.lr_wide = 4'd4; a.lr_narrow = 4'd2;
            a.bank[BANK_UND] = 1'b1;
         end
         2: begin
            a.vec_off = 5'h08; a.mode = MODE_SVC_C;
            a.lr_wide = 4'd4; a.lr_narrow = 4'd2;
            a.bank[BANK_SVC] = 1'b1;
         end
         3: begin
            a.vec_off = 5'h0C; a.mode = MODE_ABT_C;
            a.lr_wide = 4'd4; a.lr_narrow = 4'd4; a.set_a = 1'b1;
            a.bank[BANK_ABT] = 1'b1; a.fault = 2'b01;
         end
         4: begin
            a.vec_off = 5'h10; a.mode = MODE_ABT_C;
            a.lr_wide = 4'd8; a.lr_narrow = 4'd8; a.set_a = 1'b1;
            a.bank[BANK_ABT] = 1'b1; a.fault = 2'b10;
         end
         5: begin
            a.vec_off = 5'h18; a.mode = MODE_IRQ_C;
            a.lr_wide = 4'd4; a.lr_narrow = 4'd4; a.set_a = 1'b1;
            a.bank[BANK_IRQ] = 1'b1;
         end
         6: begin
            a.vec_off = 5'h1C; a.mode = MODE_FIQ_C;
            a.lr_wide = 4'd4; a.lr_narrow = 4'd4;
            a.set_a = 1'b1; a.set_f = 1'b1;
            a.bank[BANK_FIQ] = 1'b1;
         end
         default: a = '0;
      endcase
      return a;
   endfunction

endpackage

// File: rtl/exc_decode.sv
module exc_decode
   import exc_entry_pkg::*;
#(
   parameter int NUM_REQ = 7
) (
   input  logic [NUM_REQ-1:0] req,
   output logic               accept,
   output exc_attr_t          attr
);

   if (NUM_REQ != NUM_EXC) begin : g_bad_count
      $error("exc_decode: NUM_REQ must equal NUM_EXC");
   end

   logic [ATTR_W-1:0] term [NUM_REQ];
   logic [ATTR_W-1:0] merged;

   for (genvar g = 0; g < NUM_REQ; g++) begin : g_term
      assign term[g] = req[g] ? ATTR_W'(attr_of(g)) : '0;
   end

   always_comb begin
      merged = '0;
      for (int i = 0; i < NUM_REQ; i++) merged = merged | term[i];
   end

   assign accept = (req != '0) && ((req & (req - NUM_REQ'(1))) == '0);
   assign attr   = exc_attr_t'(merged);

endmodule

// File: rtl/exc_status_pack.sv
module exc_status_pack
   import exc_entry_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int IT_W   = 8
) (
   input  logic [DATA_W-1:0] status_in,
   input  logic [1:0]        nz,
   input  logic              c,
   input  logic              v,
   input  logic [3:0]        ge,
   input  logic [IT_W-1:0]   it,
   input  exc_attr_t         attr,
   output logic [DATA_W-1:0] saved,
   output logic [DATA_W-1:0] next
);

   if (DATA_W != 32) begin : g_bad_w
      $error("exc_status_pack: DATA_W must be 32");
   end
   if (IT_W != 8) begin : g_bad_it
      $error("exc_status_pack: IT_W must be 8");
   end

   always_comb begin
      saved = status_in;
      saved[ST_N] = nz[1];
      saved[ST_Z] = nz[0];
      saved[ST_C] = c;
      saved[ST_V] = v;
      saved[ST_GE_HI:ST_GE_LO]   = ge;
      saved[ST_ITH_HI:ST_ITH_LO] = it[IT_W-1:2];
      saved[ST_ITL_HI:ST_ITL_LO] = it[1:0];
   end

   always_comb begin
      next = status_in;
      next[4:0] = attr.mode;
      next[ST_ITH_HI:ST_ITH_LO] = '0;
      next[ST_ITL_HI:ST_ITL_LO] = '0;
      next[ST_I] = 1'b1;
      next[ST_A] = status_in[ST_A] | attr.set_a;
      next[ST_F] = status_in[ST_F] | attr.set_f;
   end

endmodule

// File: rtl/exc_fault_pack.sv
module exc_fault_pack #(
   parameter int FS_W   = 5,
   parameter int DATA_W = 32
) (
   input  logic [FS_W-1:0]   cause,
   input  logic              store,
   output logic [DATA_W-1:0] fsr
);

   localparam int LOW_W   = 4;
   localparam int HIGH_AT = 10;
   localparam int WNR_AT  = 11;

   if (FS_W != LOW_W + 1) begin : g_bad_fs
      $error("exc_fault_pack: FS_W must be 5");
   end

   always_comb begin
      fsr = '0;
      fsr[LOW_W-1:0] = cause[LOW_W-1:0];
      fsr[HIGH_AT]   = cause[FS_W-1];
      fsr[WNR_AT]    = store;
   end

endmodule

// File: rtl/exc_entry.sv
module exc_entry
   import exc_entry_pkg::*;
#(
   parameter int          ADDR_W      = 32,
   parameter int          IT_W        = 8,
   parameter int          FS_W        = 5,
   parameter bit          HIGH_VEC_EN = 1'b1,
   parameter logic [31:0] HIGH_BASE   = 32'hFFFF_0000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [6:0]        exc_req,
   input  logic [ADDR_W-1:0] pc_cur,
   input  logic [31:0]       status_cur,
   input  logic [1:0]        flag_nz,
   input  logic              flag_c,
   input  logic              flag_v,
   input  logic [3:0]        flag_ge,
   input  logic [IT_W-1:0]   it_state,
   input  logic              vec_high,
   input  logic [FS_W-1:0]   abt_status,
   input  logic [ADDR_W-1:0] abt_addr,
   input  logic              abt_write,
   output logic              entry_valid,
   output logic [31:0]       status_next,
   output logic [4:0]        spsr_wr,
   output logic [31:0]       spsr_data,
   output logic              lr_wr,
   output logic [ADDR_W-1:0] lr_data,
   output logic [ADDR_W-1:0] pc_next,
   output logic [1:0]        fsr_wr,
   output logic [31:0]       fsr_data,
   output logic [ADDR_W-1:0] far_data,
   output logic              mailbox_set,
   output logic              irq_clear_all
);

   if (ADDR_W != 32) begin : g_bad_addr
      $error("exc_entry: ADDR_W must be 32");
   end

   logic              accept;
   exc_attr_t         attr;
   logic [31:0]       saved_c;
   logic [31:0]       next_c;
   logic [31:0]       fsr_c;
   logic [ADDR_W-1:0] lr_c;
   logic [ADDR_W-1:0] pc_c;
   logic [3:0]        lr_off;

   exc_decode #(.NUM_REQ(NUM_EXC)) u_decode (
      .req    (exc_req),
      .accept (accept),
      .attr   (attr)
   );

   exc_status_pack #(.DATA_W(32), .IT_W(IT_W)) u_status (
      .status_in (status_cur),
      .nz        (flag_nz),
      .c         (flag_c),
      .v         (flag_v),
      .ge        (flag_ge),
      .it        (it_state),
      .attr      (attr),
      .saved     (saved_c),
      .next      (next_c)
   );

   exc_fault_pack #(.FS_W(FS_W), .DATA_W(32)) u_fault (
      .cause (abt_status),
      .store (abt_write),
      .fsr   (fsr_c)
   );

   assign lr_off = status_cur[ST_T] ? attr.lr_narrow : attr.lr_wide;
   assign lr_c   = pc_cur + ADDR_W'(lr_off);

   if (HIGH_VEC_EN) begin : g_hivec
      assign pc_c = vec_high ? (HIGH_BASE | ADDR_W'(attr.vec_off))
                             : ADDR_W'(attr.vec_off);
   end else begin : g_lovec
      logic unused_hv;
      assign unused_hv = vec_high;
      assign pc_c      = ADDR_W'(attr.vec_off);
   end

   // strobes: pulse only for one cycle after an accepted request
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         entry_valid   <= 1'b0;
         spsr_wr       <= '0;
         lr_wr         <= 1'b0;
         fsr_wr        <= '0;
         mailbox_set   <= 1'b0;
         irq_clear_all <= 1'b0;
      end else begin
         entry_valid   <= accept;
         spsr_wr       <= accept ? attr.bank : '0;
         lr_wr         <= accept;
         fsr_wr        <= accept ? attr.fault : '0;
         mailbox_set   <= accept;
         irq_clear_all <= accept & attr.is_reset;
      end
   end

   // data: loaded only on acceptance
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         status_next <= '0;
         spsr_data   <= '0;
         lr_data     <= '0;
         pc_next     <= '0;
         fsr_data    <= '0;
         far_data    <= '0;
      end else if (accept) begin
         status_next <= next_c;
         spsr_data   <= saved_c;
         lr_data     <= lr_c;
         pc_next     <= pc_c;
         fsr_data    <= (attr.fault != 2'b00) ? fsr_c : '0;
         far_data    <= (attr.fault != 2'b00) ? abt_addr : '0;
      end
   end

   assert_accept_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(exc_req) == 1) |=> entry_valid);

   assert_multihot_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(exc_req) > 1) |=> (!entry_valid && spsr_wr == '0));

   assert_idle_strobes_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !entry_valid |-> (spsr_wr == '0 && fsr_wr == '0 && !lr_wr && !mailbox_set && !irq_clear_all));

   assert_single_bank_R1: assert property (@(posedge clk) disable iff (!rst_n)
      entry_valid |-> ($countones(spsr_wr) == 1));

   assert_it_cleared_R5: assert property (@(posedge clk) disable iff (!rst_n)
      entry_valid |-> (status_next[ST_ITH_HI:ST_ITH_LO] == '0 && status_next[ST_ITL_HI:ST_ITL_LO] == '0));

   assert_irq_mask_R4: assert property (@(posedge clk) disable iff (!rst_n)
      entry_valid |-> status_next[ST_I]);

   assert_fiq_mask_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (entry_valid && status_next[4:0] == MODE_FIQ_C) |-> status_next[ST_F]);

   assert_fault_mode_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (fsr_wr != '0) |-> (status_next[4:0] == MODE_ABT_C && $countones(fsr_wr) == 1));

   assert_vector_align_R2: assert property (@(posedge clk) disable iff (!rst_n)
      entry_valid |-> (pc_next[1:0] == 2'b00));

   assert_reset_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      irq_clear_all |-> (mailbox_set && status_next[4:0] == MODE_SVC_C));

endmodule

// File: tb/test_exc_entry.sv
module test_exc_entry;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [6:0]  exc_req = '0;
   logic [31:0] pc_cur = '0;
   logic [31:0] status_cur = '0;
   logic [1:0]  flag_nz = '0;
   logic        flag_c = 1'b0;
   logic        flag_v = 1'b0;
   logic [3:0]  flag_ge = '0;
   logic [7:0]  it_state = '0;
   logic        vec_high = 1'b0;
   logic [4:0]  abt_status = '0;
   logic [31:0] abt_addr = '0;
   logic        abt_write = 1'b0;
   logic        entry_valid;
   logic [31:0] status_next;
   logic [4:0]  spsr_wr;
   logic [31:0] spsr_data;
   logic        lr_wr;
   logic [31:0] lr_data;
   logic [31:0] pc_next;
   logic [1:0]  fsr_wr;
   logic [31:0] fsr_data;
   logic [31:0] far_data;
   logic        mailbox_set;
   logic        irq_clear_all;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   exc_entry i_exc_entry (
      .clk(clk), .rst_n(rst_n), .exc_req(exc_req), .pc_cur(pc_cur),
      .status_cur(status_cur), .flag_nz(flag_nz), .flag_c(flag_c),
      .flag_v(flag_v), .flag_ge(flag_ge), .it_state(it_state),
      .vec_high(vec_high), .abt_status(abt_status), .abt_addr(abt_addr),
      .abt_write(abt_write), .entry_valid(entry_valid),
      .status_next(status_next), .spsr_wr(spsr_wr), .spsr_data(spsr_data),
      .lr_wr(lr_wr), .lr_data(lr_data), .pc_next(pc_next), .fsr_wr(fsr_wr),
      .fsr_data(fsr_data), .far_data(far_data), .mailbox_set(mailbox_set),
      .irq_clear_all(irq_clear_all)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   // expected attributes from the requirement text
   task automatic expect_of(input int k, output logic [4:0] mode, output logic [31:0] off,
                            output int lr_a, output int lr_t, output logic sa, output logic sf,
                            output logic [4:0] bank, output logic [1:0] flt);
      sa = 1'b0; sf = 1'b0; flt = 2'b00;
      case (k)
         0: begin mode = 5'h13; off = 32'h00; lr_a = 0; lr_t = 0; sa = 1; sf = 1; bank = 5'b00100; end
         1: begin mode = 5'h1B; off = 32'h04; lr_a = 4; lr_t = 2; bank = 5'b01000; end
         2: begin mode = 5'h13; off = 32'h08; lr_a = 4; lr_t = 2; bank = 5'b00100; end
         3: begin mode = 5'h17; off = 32'h0C; lr_a = 4; lr_t = 4; sa = 1; bank = 5'b10000; flt = 2'b01; end
         4: begin mode = 5'h17; off = 32'h10; lr_a = 8; lr_t = 8; sa = 1; bank = 5'b10000; flt = 2'b10; end
         5: begin mode = 5'h12; off = 32'h18; lr_a = 4; lr_t = 4; sa = 1; bank = 5'b00010; end
         default: begin mode = 5'h11; off = 32'h1C; lr_a = 4; lr_t = 4; sa = 1; sf = 1; bank = 5'b00001; end
      endcase
   endtask

   // drive one request at a falling edge, check at the next falling edge
   task automatic run_one(input int k, input logic thumb, input logic hv, input logic [31:0] base);
      logic [4:0] mode; logic [31:0] off; int lr_a; int lr_t;
      logic sa; logic sf; logic [4:0] bank; logic [1:0] flt;
      logic [31:0] es; logic [31:0] en; logic [31:0] efsr;
      expect_of(k, mode, off, lr_a, lr_t, sa, sf, bank, flt);
      exc_req    = 7'(1) << k;
      status_cur = base;
      status_cur[5] = thumb;
      vec_high   = hv;
      pc_cur     = 32'h0000_8000 + 32'(k * 16);
      es = status_cur;
      es[31] = flag_nz[1]; es[30] = flag_nz[0]; es[29] = flag_c; es[28] = flag_v;
      es[19:16] = flag_ge; es[15:10] = it_state[7:2]; es[26:25] = it_state[1:0];
      en = status_cur;
      en[4:0] = mode; en[15:10] = '0; en[26:25] = '0; en[7] = 1'b1;
      if (sa) en[8] = 1'b1;
      if (sf) en[6] = 1'b1;
      efsr = '0;
      efsr[3:0] = abt_status[3:0]; efsr[10] = abt_status[4]; efsr[11] = abt_write;
      @(negedge clk);
      exc_req = '0;
      chk($sformatf("R8 valid k=%0d", k), 32'(entry_valid), 32'd1);
      chk($sformatf("R1 mode k=%0d", k), 32'(status_next[4:0]), 32'(mode));
      chk($sformatf("R1 bank k=%0d", k), 32'(spsr_wr), 32'(bank));
      chk($sformatf("R2 pc k=%0d hv=%0d", k, hv), pc_next, hv ? (32'hFFFF_0000 + off) : off);
      chk($sformatf("R3 lr k=%0d t=%0d", k, thumb), lr_data,
          pc_cur + 32'(thumb ? lr_t : lr_a));
      chk($sformatf("R3 lr_wr k=%0d", k), 32'(lr_wr), 32'd1);
      chk($sformatf("R4 R5 status k=%0d", k), status_next, en);
      chk($sformatf("R5 saved k=%0d", k), spsr_data, es);
      chk($sformatf("R6 fsr_wr k=%0d", k), 32'(fsr_wr), 32'(flt));
      if (flt != 2'b00) begin
         chk($sformatf("R6 fsr k=%0d", k), fsr_data, efsr);
         chk($sformatf("R6 far k=%0d", k), far_data, abt_addr);
      end
      chk($sformatf("R7 mailbox k=%0d", k), 32'(mailbox_set), 32'd1);
      chk($sformatf("R7 irq_clear k=%0d", k), 32'(irq_clear_all), (k == 0) ? 32'd1 : 32'd0);
   endtask

   task automatic t_reset_state();
      chk("R10 valid", 32'(entry_valid), 0);
      chk("R10 status", status_next, 0);
      chk("R10 strobes", {22'd0, spsr_wr, lr_wr, fsr_wr, mailbox_set, irq_clear_all}, 0);
      chk("R10 data", lr_data | pc_next | spsr_data | fsr_data | far_data, 0);
   endtask

   task automatic t_all_kinds_arm_low();
      flag_nz = 2'b10; flag_c = 1; flag_v = 0; flag_ge = 4'hA; it_state = 8'b1011_0110;
      for (int k = 0; k < 7; k++) run_one(k, 1'b0, 1'b0, 32'h0000_0010);
   endtask

   task automatic t_all_kinds_thumb_high();
      flag_nz = 2'b01; flag_c = 0; flag_v = 1; flag_ge = 4'h5; it_state = 8'b0100_1101;
      for (int k = 0; k < 7; k++) run_one(k, 1'b1, 1'b1, 32'h0000_0010);
   endtask

   task automatic t_masks_kept();
      // all masks set beforehand: none may clear
      for (int k = 0; k < 7; k++) run_one(k, 1'b0, 1'b0, 32'hF000_01D0);
   endtask

   task automatic t_abort_fields();
      abt_status = 5'h1A; abt_write = 1; abt_addr = 32'hDEAD_BEE0;
      run_one(3, 1'b0, 1'b0, 32'h10);
      abt_status = 5'h05; abt_write = 0; abt_addr = 32'h1234_5678;
      run_one(4, 1'b1, 1'b0, 32'h10);
   endtask

   task automatic t_idle_and_multihot();
      exc_req = '0;
      @(negedge clk);
      chk("R8 idle valid", 32'(entry_valid), 0);
      chk("R8 idle strobes", {25'd0, spsr_wr, lr_wr, mailbox_set}, 0);
      exc_req = 7'b010_0001;
      @(negedge clk);
      exc_req = '0;
      chk("R9 multihot valid", 32'(entry_valid), 0);
      chk("R9 multihot strobes", {24'd0, spsr_wr, fsr_wr, irq_clear_all}, 0);
      exc_req = 7'b001_1000;
      @(negedge clk);
      exc_req = '0;
      chk("R9 multihot abort fsr", 32'(fsr_wr), 0);
   endtask

   task automatic t_back_to_back();
      exc_req = 7'b010_0000; status_cur = 32'h10; vec_high = 0;
      @(negedge clk);
      chk("R8 b2b first", pc_next, 32'h18);
      exc_req = 7'b100_0000;
      @(negedge clk);
      exc_req = '0;
      chk("R8 b2b second valid", 32'(entry_valid), 1);
      chk("R8 b2b second pc", pc_next, 32'h1C);
      @(negedge clk);
      chk("R8 b2b drop", 32'(entry_valid), 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset_state();
      rst_n = 1'b1;
      @(negedge clk);
      t_all_kinds_arm_low();
      t_all_kinds_thumb_high();
      t_masks_kept();
      t_abort_fields();
      t_idle_and_multihot();
      t_back_to_back();
      finish_run();
   end

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
   end

endmodule